// File: doc/BRIEF.md
# Coprocessor Integer ALU

This block carries out the integer data-processing operations of a coprocessor whose sixteen registers are 64 bits wide each. Every instruction names an operation group, a sub-opcode, a destination and up to two source registers. The block drives three combinational read addresses into the register file and takes back the three read words. One clock edge after an accepted instruction, it presents a single registered write (enable, address, 64-bit data) for that file. Instructions that decode to float-to-integer conversions are not executed. They raise a one-cycle unsupported-operation flag instead of writing.

A 32-bit integer lives in the low half of a register. A 64-bit integer spans the whole register, with the low half as its least significant word. Shifts take a 7-bit two's-complement amount built from two separate instruction fields, and the sign of that amount picks the direction. A small state machine (ST_IDLE, ST_COMMIT, ST_REJECT) drives the outputs. Each cycle with `instr_valid` moves it to ST_COMMIT if the instruction is supported, or to ST_REJECT if it is not. A cycle without `instr_valid` returns it to ST_IDLE. When the previous result has not yet reached the file, operand reads that hit that result's address are forwarded from it.

Top module: `cia_int_alu`

## Requirements
- R1: Field positions: operation group = instr[21:20], sub-opcode = instr[7:5], destination = instr[15:12], first source = instr[19:16], second source = instr[3:0]. A supported instruction writes the destination address.
- R2: Groups 0 and 2 are shifts. The amount is the signed 7-bit value {instr[7:5], instr[3:0]}, with instr[7] as the sign. A negative amount is an arithmetic right shift by its magnitude, and a zero or positive amount is a left shift. Group 0 shifts the low 32 bits of the first source; group 2 shifts all 64 bits. Shifting by the full width or more gives zero for a left shift and the sign fill for a right shift.
- R3: In group 1, sub-opcode 0 writes the low 32 bits of the product of the two sources' low halves. Sub-opcode 1 writes the low 64 bits of the full-register product.
- R4: In group 1, sub-opcode 2 adds the 32-bit product to the destination's old low half, and sub-opcode 3 subtracts it from that half.
- R5: In group 3, the sub-opcode selects abs, neg, add or sub. Its bits [2:1] pick the operation (0 = abs, 1 = neg, 2 = add, 3 = sub), and its bit 0 selects 64-bit width (1) or 32-bit width (0).
- R6: A 32-bit operation writes its result to the low half of the destination and keeps the destination's previous upper half. A 64-bit operation writes all 64 bits.
- R7: Results wrap modulo 2^32 or 2^64, with no saturation. The absolute value of the most negative number is that same number.
- R8: Group 1 sub-opcodes 4 to 7 raise `illegal_op` for exactly one cycle and produce no write. `illegal_op` and `wr_en` are never high together.
- R9: `wr_en` is high for exactly the one cycle after each supported instruction is accepted, and it is low in any cycle that does not follow an accepted instruction.
- R10: An instruction accepted in the cycle right after another one sees that earlier result in place of the file contents at the same address.
- R11: While `rst_n` is low, and in the cycle after it rises, `wr_en` and `illegal_op` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| rs1_addr | output | 4 | First source read address |
| rs2_addr | output | 4 | Second source read address |
| rd_addr | output | 4 | Destination read address (accumulate and upper-half keep) |
| rs1_data | input | 64 | First source read data |
| rs2_data | input | 64 | Second source read data |
| rd_data | input | 64 | Destination old contents |
| wr_en | output | 1 | Register file write enable |
| wr_addr | output | 4 | Register file write address |
| wr_data | output | 64 | Register file write data |
| illegal_op | output | 1 | Unsupported operation, one cycle |

## Verification
The bench walks shifts at the amount extremes: +63 and -64, the -64 case on both widths, and zero. A design that treated the amount as unsigned, or filled right shifts with zeros, would write the wrong word. It checks that 32-bit results keep the destination's upper half, since a design that zeroed or overwrote that half would lose the marker value stored there. It also checks that a 32-bit add does not carry into bit 32, while a 64-bit add does carry across the halves. Back-to-back dependent instructions check the forwarding path; without it, the second result is built from stale file contents. Each unsupported sub-opcode must raise the flag for one cycle with no write; an error here shows up as a stray write or a flag that stays high.

// File: rtl/cia_pkg.sv
package cia_pkg;

    // Instruction field positions; the decoder and checker rely on them.
    localparam int GRP_LSB = 20;
    localparam int SUB_LSB = 5;
    localparam int RD_LSB  = 12;
    localparam int RS1_LSB = 16;
    localparam int RS2_LSB = 0;
    localparam int SHL_LSB = 0;   // low four bits of the shift amount

    typedef enum logic [1:0] {
        GRP_SHIFT32 = 2'd0,
        GRP_MULT    = 2'd1,
        GRP_SHIFT64 = 2'd2,
        GRP_ARITH   = 2'd3
    } grp_e;

    typedef enum logic [3:0] {
        OP_SH32, OP_SH64,
        OP_MUL32, OP_MUL64, OP_MAC32, OP_MSC32,
        OP_ABS32, OP_ABS64, OP_NEG32, OP_NEG64,
        OP_ADD32, OP_ADD64, OP_SUB32, OP_SUB64,
        OP_NONE
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_REJECT = 2'd2
    } state_e;

    typedef struct packed {
        op_e               op;
        logic              legal;
        logic              wide;
        logic signed [7:0] shamt;
    } dec_t;

endpackage

// File: rtl/cia_decode.sv
module cia_decode
    import cia_pkg::*;
#(
    parameter int IW = 32,
    parameter int AW = 4
) (
    input  logic [IW-1:0] instr,
    output dec_t          dec,
    output logic [AW-1:0] rd_a,
    output logic [AW-1:0] rs1_a,
    output logic [AW-1:0] rs2_a
);

    logic [1:0] grp;
    logic [2:0] sub;
    logic [6:0] amt7;
    logic       unused_fields;

    assign grp   = instr[GRP_LSB +: 2];
    assign sub   = instr[SUB_LSB +: 3];
    assign rd_a  = instr[RD_LSB  +: AW];
    assign rs1_a = instr[RS1_LSB +: AW];
    assign rs2_a = instr[RS2_LSB +: AW];
    assign amt7  = {sub, instr[SHL_LSB +: 4]};

    assign unused_fields = ^{instr[IW-1:GRP_LSB+2], instr[11:8], instr[4]};

    always_comb begin
        dec.op    = OP_NONE;
        dec.legal = 1'b1;
        dec.wide  = 1'b0;
        dec.shamt = {amt7[6], amt7};
        unique case (grp_e'(grp))
            GRP_SHIFT32: dec.op = OP_SH32;
            GRP_SHIFT64: begin
                dec.op   = OP_SH64;
                dec.wide = 1'b1;
            end
            GRP_MULT: begin
                unique case (sub)
                    3'd0:    dec.op = OP_MUL32;
                    3'd1: begin
                        dec.op   = OP_MUL64;
                        dec.wide = 1'b1;
                    end
                    3'd2:    dec.op = OP_MAC32;
                    3'd3:    dec.op = OP_MSC32;
                    default: dec.legal = 1'b0;   // conversions: unsupported
                endcase
            end
            GRP_ARITH: begin
                dec.wide = sub[0];
                unique case (sub[2:1])
                    2'd0: dec.op = sub[0] ? OP_ABS64 : OP_ABS32;
                    2'd1: dec.op = sub[0] ? OP_NEG64 : OP_NEG32;
                    2'd2: dec.op = sub[0] ? OP_ADD64 : OP_ADD32;
                    2'd3: dec.op = sub[0] ? OP_SUB64 : OP_SUB32;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/cia_shifter.sv
module cia_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0]      src,
    input  logic signed [7:0] amt,
    output logic [W-1:0]      res
);

    localparam logic [7:0] WLIM = 8'(W);

    logic       go_right;
    logic [7:0] mag;

    always_comb begin
        go_right = amt[7];
        mag      = go_right ? 8'(-amt) : 8'(amt);
        if (go_right) begin
            if (mag >= WLIM) res = {W{src[W-1]}};
            else             res = W'($signed(src) >>> mag);
        end else begin
            if (mag >= WLIM) res = '0;
            else             res = W'(src << mag);
        end
    end

endmodule

// File: rtl/cia_arith.sv
module cia_arith
    import cia_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  op_e              op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [XLEN-1:0]  acc,
    output logic [XLEN/2-1:0] lo_res,
    output logic [XLEN-1:0]  full_res
);

    localparam int HALF = XLEN / 2;

    logic [HALF-1:0] a_lo, b_lo, acc_lo, prod_lo;
    logic [XLEN-1:0] prod_full;

    assign a_lo      = a[HALF-1:0];
    assign b_lo      = b[HALF-1:0];
    assign acc_lo    = acc[HALF-1:0];
    assign prod_lo   = a_lo * b_lo;
    assign prod_full = a * b;

    always_comb begin
        lo_res   = '0;
        full_res = '0;
        unique case (op)
            OP_MUL32: lo_res   = prod_lo;
            OP_MUL64: full_res = prod_full;
            OP_MAC32: lo_res   = acc_lo + prod_lo;
            OP_MSC32: lo_res   = acc_lo - prod_lo;
            OP_ABS32: lo_res   = a_lo[HALF-1] ? -a_lo : a_lo;
            OP_ABS64: full_res = a[XLEN-1] ? -a : a;
            OP_NEG32: lo_res   = -a_lo;
            OP_NEG64: full_res = -a;
            OP_ADD32: lo_res   = a_lo + b_lo;
            OP_ADD64: full_res = a + b;
            OP_SUB32: lo_res   = a_lo - b_lo;
            OP_SUB64: full_res = a - b;
            default: begin
                lo_res   = '0;
                full_res = '0;
            end
        endcase
    end

endmodule

// File: rtl/cia_int_alu.sv
module cia_int_alu
    import cia_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 16,
    parameter int IW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [IW-1:0]   instr,
    output logic [AW-1:0]   rs1_addr,
    output logic [AW-1:0]   rs2_addr,
    output logic [AW-1:0]   rd_addr,
    input  logic [XLEN-1:0] rs1_data,
    input  logic [XLEN-1:0] rs2_data,
    input  logic [XLEN-1:0] rd_data,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [XLEN-1:0] wr_data,
    output logic            illegal_op
);

    localparam int HALF = XLEN / 2;

    dec_t            dec;
    state_e          state, state_nxt;
    logic [XLEN-1:0] src1, src2, dst_old;
    logic [HALF-1:0] sh32_res, ar_lo, lo_sel;
    logic [XLEN-1:0] sh64_res, ar_full, full_sel, result;
    logic [AW-1:0]   wr_addr_q;
    logic [XLEN-1:0] wr_data_q;

    cia_decode #(.IW(IW), .AW(AW)) u_dec (
        .instr (instr),
        .dec   (dec),
        .rd_a  (rd_addr),
        .rs1_a (rs1_addr),
        .rs2_a (rs2_addr)
    );

    // Forward the pending write to reads of the same register.
    always_comb begin
        src1    = (wr_en && wr_addr_q == rs1_addr) ? wr_data_q : rs1_data;
        src2    = (wr_en && wr_addr_q == rs2_addr) ? wr_data_q : rs2_data;
        dst_old = (wr_en && wr_addr_q == rd_addr)  ? wr_data_q : rd_data;
    end

    cia_shifter #(.W(HALF)) u_sh_half (
        .src (src1[HALF-1:0]),
        .amt (dec.shamt),
        .res (sh32_res)
    );

    cia_shifter #(.W(XLEN)) u_sh_full (
        .src (src1),
        .amt (dec.shamt),
        .res (sh64_res)
    );

    cia_arith #(.XLEN(XLEN)) u_arith (
        .op       (dec.op),
        .a        (src1),
        .b        (src2),
        .acc      (dst_old),
        .lo_res   (ar_lo),
        .full_res (ar_full)
    );

    always_comb begin
        lo_sel   = (dec.op == OP_SH32) ? sh32_res : ar_lo;
        full_sel = (dec.op == OP_SH64) ? sh64_res : ar_full;
        result   = dec.wide ? full_sel : {dst_old[XLEN-1:HALF], lo_sel};
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions: every state accepts a new instruction each cycle.
    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_COMMIT, ST_REJECT: begin
                if (instr_valid) state_nxt = dec.legal ? ST_COMMIT : ST_REJECT;
                else             state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else if (instr_valid && dec.legal) begin
            wr_addr_q <= rd_addr;
            wr_data_q <= result;
        end
    end

    // Outputs
    always_comb begin
        wr_en      = 1'b0;
        illegal_op = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_COMMIT: wr_en      = 1'b1;
            ST_REJECT: illegal_op = 1'b1;
            default:   ;
        endcase
        wr_addr = wr_addr_q;
        wr_data = wr_data_q;
    end

endmodule

// File: rtl/cia_alu_checker.sv
module cia_alu_checker #(
    parameter int XLEN = 64,
    parameter int AW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [1:0]      grp,
    input logic            sub_msb,
    input logic [AW-1:0]   dest,
    input logic [XLEN/2-1:0] old_hi,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [XLEN-1:0] wr_data,
    input logic            illegal_op
);

    localparam int HALF = XLEN / 2;

    logic bad_op;
    assign bad_op = (grp == 2'd1) && sub_msb;

    a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && illegal_op));

    a_r9_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!wr_en && !illegal_op));

    a_r8_flag_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && bad_op) |=> (illegal_op && !wr_en));

    a_r1_dest_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !bad_op) |=> (wr_en && wr_addr == $past(dest)));

    a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && grp == 2'd0 && !(wr_en && wr_addr == dest))
        |=> (wr_data[XLEN-1:HALF] == $past(old_hi)));

    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!wr_en && !illegal_op));

endmodule

bind cia_int_alu cia_alu_checker #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .grp         (instr[21:20]),
    .sub_msb     (instr[7]),
    .dest        (instr[12 +: AW]),
    .old_hi      (rd_data[XLEN-1:XLEN/2]),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .illegal_op  (illegal_op)
);

// File: tb/cia_int_alu_test.sv
`timescale 1ns/1ps
module cia_int_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  rs1_addr, rs2_addr, rd_addr, wr_addr;
    logic [63:0] rs1_data, rs2_data, rd_data, wr_data;
    logic        wr_en, illegal_op;

    logic [63:0] rf [16];
    logic        pl_en = 1'b0;
    logic [3:0]  pl_addr = '0;
    logic [63:0] pl_data = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    cia_int_alu uut (
        .clk, .rst_n, .instr_valid, .instr,
        .rs1_addr, .rs2_addr, .rd_addr,
        .rs1_data, .rs2_data, .rd_data,
        .wr_en, .wr_addr, .wr_data, .illegal_op
    );

    // Bench-owned register file
    assign rs1_data = rf[rs1_addr];
    assign rs2_data = rf[rs2_addr];
    assign rd_data  = rf[rd_addr];
    always @(posedge clk) begin
        if (wr_en) rf[wr_addr] <= wr_data;
        if (pl_en) rf[pl_addr] <= pl_data;
    end

    typedef struct packed {
        logic [31:0] ins;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] d;
        logic [63:0] exp;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    localparam logic [63:0] DM = 64'hCAFE0000_00000005;
    localparam int NV = 23;
    // rd=1, rs1=2, rs2=3 (shifts: amount in sub/rs2 fields)
    localparam vec_t VECS [NV] = '{
        '{32'h00021004, 64'h11111111_000000F1, 64'h0, DM, 64'hCAFE0000_00000F10, 1'b0, 8'd2}, // R2 +4
        '{32'h000210EC, 64'h00000000_80000010, 64'h0, DM, 64'hCAFE0000_F8000001, 1'b0, 8'd2}, // R2 -4
        '{32'h00021080, 64'h00000000_80000000, 64'h0, DM, 64'hCAFE0000_FFFFFFFF, 1'b0, 8'd2}, // R2 -64
        '{32'h0002106F, 64'h00000000_FFFFFFFF, 64'h0, DM, 64'hCAFE0000_00000000, 1'b0, 8'd2}, // R2 +63
        '{32'h00021000, 64'h00000000_12345678, 64'h0, DM, 64'hCAFE0000_12345678, 1'b0, 8'd6}, // R6 zero
        '{32'h00221008, 64'h00112233_44556677, 64'h0, DM, 64'h11223344_55667700, 1'b0, 8'd2}, // R2 64 +8
        '{32'h002210E8, 64'h80000000_00000100, 64'h0, DM, 64'hFF800000_00000001, 1'b0, 8'd2}, // R2 64 -8
        '{32'h00221080, 64'h7FFFFFFF_FFFFFFFF, 64'h0, DM, 64'h0,                 1'b0, 8'd2}, // R2 64 -64
        '{32'h00121003, 64'h99999999_00000007, 64'hFFFFFFFD, DM, 64'hCAFE0000_FFFFFFEB, 1'b0, 8'd3}, // R3
        '{32'h00121023, 64'h00000001_00000000, 64'h3, DM, 64'h00000003_00000000, 1'b0, 8'd3},   // R3
        '{32'h00121023, 64'h80000000_00000000, 64'h2, DM, 64'h0,                 1'b0, 8'd7},   // R7
        '{32'h00121043, 64'h3, 64'h4, DM, 64'hCAFE0000_00000011, 1'b0, 8'd4},                  // R4 mac
        '{32'h00121063, 64'h3, 64'h4, DM, 64'hCAFE0000_FFFFFFF9, 1'b0, 8'd4},                  // R4 msc
        '{32'h00121083, 64'h3, 64'h4, DM, 64'h0,                 1'b1, 8'd8},                  // R8
        '{32'h00321003, 64'hFFFFFFF6, 64'h0, DM, 64'hCAFE0000_0000000A, 1'b0, 8'd5},           // R5 abs32
        '{32'h00321003, 64'h80000000, 64'h0, DM, 64'hCAFE0000_80000000, 1'b0, 8'd7},           // R7
        '{32'h00321023, 64'hFFFFFFFF_FFFFFFFF, 64'h0, DM, 64'h1, 1'b0, 8'd5},                  // R5 abs64
        '{32'h00321043, 64'h1, 64'h0, DM, 64'hCAFE0000_FFFFFFFF, 1'b0, 8'd5},                  // R5 neg32
        '{32'h00321063, 64'h1, 64'h0, DM, 64'hFFFFFFFF_FFFFFFFF, 1'b0, 8'd5},                  // R5 neg64
        '{32'h00321083, 64'hFFFFFFFF, 64'h2, DM, 64'hCAFE0000_00000001, 1'b0, 8'd7},           // R7 add32
        '{32'h003210A3, 64'hFFFFFFFF, 64'h1, DM, 64'h00000001_00000000, 1'b0, 8'd5},           // R5 add64
        '{32'h003210C3, 64'h2, 64'h5, DM, 64'hCAFE0000_FFFFFFFD, 1'b0, 8'd5},                  // R5 sub32
        '{32'h003210E3, 64'h0, 64'h1, DM, 64'hFFFFFFFF_FFFFFFFF, 1'b0, 8'd5}                   // R5 sub64
    };

    function automatic logic [31:0] mk(input logic [1:0] g, input logic [2:0] s,
                                       input logic [3:0] rd, input logic [3:0] r1,
                                       input logic [3:0] r2);
        return {10'b0, g, r1, rd, 4'b0, s, 1'b0, r2};
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] ad, input logic [63:0] v);
        pl_en = 1'b1; pl_addr = ad; pl_data = v;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = '0;
        // R11: reset holds the outputs low even with a valid instruction
        instr_valid = 1'b1;
        instr = mk(2'd3, 3'd4, 4'd1, 4'd2, 4'd3);
        repeat (3) @(negedge clk);
        chk(!wr_en, "R11", "wr_en in reset", 64'(wr_en), 64'h0);
        chk(!illegal_op, "R11", "illegal in reset", 64'(illegal_op), 64'h0);
        instr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en && !illegal_op, "R11", "after reset", 64'({wr_en, illegal_op}), 64'h0);
        // R9: idle cycles write nothing
        @(negedge clk);
        chk(!wr_en, "R9", "idle", 64'(wr_en), 64'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rq;
            v = VECS[i];
            rq = $sformatf("R%0d", v.req);
            load(4'd2, v.a);
            load(4'd3, v.b);
            load(4'd1, v.d);
            instr = v.ins;
            instr_valid = 1'b1;
            @(negedge clk);
            instr_valid = 1'b0;
            chk(wr_en == !v.ill, rq, "wr_en", 64'(wr_en), 64'(!v.ill));
            chk(illegal_op == v.ill, rq, "illegal", 64'(illegal_op), 64'(v.ill));
            if (!v.ill) begin
                chk(wr_data == v.exp, rq, "data", wr_data, v.exp);
                chk(wr_addr == 4'd1, "R1", "addr", 64'(wr_addr), 64'h1);
            end
            @(negedge clk);
            chk(!wr_en && !illegal_op, "R9", "one pulse", 64'({wr_en, illegal_op}), 64'h0);
        end

        // R8: remaining unsupported sub-opcodes, one-cycle flag, no write
        for (int s = 5; s < 8; s++) begin
            instr = mk(2'd1, 3'(s), 4'd1, 4'd2, 4'd3);
            instr_valid = 1'b1;
            @(negedge clk);
            instr_valid = 1'b0;
            chk(illegal_op && !wr_en, "R8", "unsupported", 64'({illegal_op, wr_en}), 64'h2);
            @(negedge clk);
            chk(!illegal_op, "R8", "flag one cycle", 64'(illegal_op), 64'h0);
        end

        // R10: back-to-back dependent instructions
        load(4'd2, 64'h5);
        load(4'd3, 64'h7);
        load(4'd4, 64'hAAAA0000_00000000);
        instr = mk(2'd3, 3'd4, 4'd4, 4'd2, 4'd3);   // add32 r4 = r2 + r3
        instr_valid = 1'b1;
        @(negedge clk);
        chk(wr_data == 64'hAAAA0000_0000000C, "R6", "add32 keeps upper", wr_data,
            64'hAAAA0000_0000000C);
        instr = mk(2'd3, 3'd5, 4'd5, 4'd4, 4'd4);   // add64 r5 = r4 + r4
        @(negedge clk);
        instr_valid = 1'b0;
        chk(wr_en && wr_data == 64'h55540000_00000018, "R10", "forwarded", wr_data,
            64'h55540000_00000018);
        // R4 with forwarded accumulator: mac32 r5 += r2 * r3 right after
        instr = mk(2'd1, 3'd2, 4'd5, 4'd2, 4'd3);
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(wr_data == 64'h55540000_0000003B, "R4", "mac forwarded acc", wr_data,
            64'h55540000_0000003B);
        @(negedge clk);
        chk(!wr_en, "R9", "end idle", 64'(wr_en), 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule